// File: doc/BRIEF.md
# Cartridge Mapper with Cycle-Counting Interrupt

This block sits on the write side of an 8-bit CPU bus inside a cartridge memory mapper. It watches CPU writes, which carry a 16-bit address, 8-bit data and a strobe. It keeps three pieces of state from those writes:

- a 16-bit reload value;
- a cycle counter that runs as a 16-bit or 8-bit counter;
- a 4-bit program-ROM bank number.

A tick input, pulsed once per CPU cycle, advances the counter while counting is enabled. When the counter wraps, the block raises a level interrupt. The interrupt stays high until software clears it.

On the read side, the block turns any CPU address in the upper 32 KB window into an 18-bit ROM address. The lower 16 KB of that window follows the bank register. The upper 16 KB is fixed to the last bank. Only address bits [15:12] of a write choose which register is written. The reload value is built one 4-bit nibble per write, across four register slots.

Top module: `prg_irq_mapper`

## Requirements
- R1: A write whose address bits [15:12] are 8, 9, A or B puts data[3:0] into reload bits [3:0], [7:4], [11:8] or [15:12] respectively. The other reload bits are left as they were.
- R2: A write with address bits [15:12] = C sets three fields from the data: 8-bit mode from bit 2 (1 = 8-bit), enable from bit 1, and the kept acknowledge flag from bit 0. When bit 1 is 1, the same write also loads the whole counter from the reload value. When bit 1 is 0, the counter keeps its value.
- R3: A write with address bits [15:12] = D drives the interrupt low and copies the kept acknowledge flag into enable.
- R4: In 16-bit mode, each tick while enabled adds one to the whole counter. A tick that carries it from 0xFFFF to 0 does three things: it raises the interrupt, copies the acknowledge flag into enable, and loads the counter from the reload value.
- R5: In 8-bit mode, each tick while enabled adds one to the counter's low byte only. When the low byte wraps from 0xFF, the block raises the interrupt, copies the acknowledge flag into enable, and reloads the low byte from reload bits [7:0]. The high byte is never changed by counting.
- R6: Once high, the interrupt stays high through any later counter wraps. Only an R3 write brings it low.
- R7: A write with address bits [15:12] = F loads data[3:0] into the bank register.
- R8: rom_addr is combinational. For cpu_addr below 0xC000 it equals bank × 0x4000 plus cpu_addr[13:0]. For cpu_addr at 0xC000 or above, the bank field is 15.
- R9: Synchronous active-low reset clears the bank register, mode, enable, acknowledge flag, reload value, counter and interrupt to zero.
- R10: A write with address bits [15:12] = E, or with an address below 0x8000, changes no register. A tick in the same cycle still counts.
- R11: When a write to any register of R1, R2, R3 or R7 lands in the same clock as a tick, the write takes effect and that tick's increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| tick | input | 1 | One pulse per CPU cycle |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 18 | Translated program-ROM address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is the counter's high byte after an 8-bit wrap. Neither the interrupt nor the ROM address shows it directly.

The stimulus reaches it in a fixed order:
1. Enable 8-bit counting with the acknowledge flag set, and let the low byte wrap.
2. Leave 8-bit mode with a control write that keeps enable off, so no reload happens.
3. Re-enable counting with a clear write.

The number of ticks to the next 16-bit wrap then shows whether the high byte survived. Dropped ticks, for both same-cycle register writes and the non-dropping unused addresses, are observed the same way, by counting ticks to the interrupt.

// File: rtl/prg_irq_mapper_pkg.sv
// Package prg_irq_mapper_pkg
// Shared register-slot codes and the decoded write command used by
// every submodule of the mapper. Assumes register selection uses the
// top address nibble only.
package prg_irq_mapper_pkg;

    localparam int NIB_W   = 4;
    localparam int SLOT_W  = 4;

    // register slot codes in address bits [15:12]
    localparam logic [SLOT_W-1:0] SLOT_LAT0 = 4'h8;
    localparam logic [SLOT_W-1:0] SLOT_LAT1 = 4'h9;
    localparam logic [SLOT_W-1:0] SLOT_LAT2 = 4'hA;
    localparam logic [SLOT_W-1:0] SLOT_LAT3 = 4'hB;
    localparam logic [SLOT_W-1:0] SLOT_CTRL = 4'hC;
    localparam logic [SLOT_W-1:0] SLOT_CLR  = 4'hD;
    localparam logic [SLOT_W-1:0] SLOT_BANK = 4'hF;

    typedef struct packed {
        logic             lat_we;
        logic [1:0]       lat_idx;
        logic             ctrl_we;
        logic             clr_we;
        logic             bank_we;
        logic [NIB_W-1:0] nib;
        logic             mode8;
        logic             en;
        logic             ack;
    } wr_cmd_t;

    // true when the command touches any register
    function automatic logic cmd_any(input wr_cmd_t c);
        return c.lat_we | c.ctrl_we | c.clr_we | c.bank_we;
    endfunction

endpackage

// File: rtl/prg_irq_mapper_decode.sv
// Module prg_irq_mapper_decode
// Turns a raw CPU write into a one-hot register command. Only the top
// address nibble selects a slot; unused slots yield an empty command.
// Assumes wr_en is a single-cycle strobe.
module prg_irq_mapper_decode
    import prg_irq_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);

    logic [SLOT_W-1:0] slot;
    logic              unused_bits;

    assign slot        = wr_addr[ADDR_W-1 -: SLOT_W];
    assign unused_bits = ^{wr_addr[ADDR_W-SLOT_W-1:0], wr_data[DATA_W-1:NIB_W]};

    // build the command from the slot code and the low data bits
    always_comb begin
        cmd       = '0;
        cmd.nib   = wr_data[NIB_W-1:0];
        cmd.mode8 = wr_data[2];
        cmd.en    = wr_data[1];
        cmd.ack   = wr_data[0];
        if (wr_en) begin
            case (slot)
                SLOT_LAT0, SLOT_LAT1, SLOT_LAT2, SLOT_LAT3: begin
                    cmd.lat_we  = 1'b1;
                    cmd.lat_idx = slot[1:0];
                end
                SLOT_CTRL: cmd.ctrl_we = 1'b1;
                SLOT_CLR:  cmd.clr_we  = 1'b1;
                SLOT_BANK: cmd.bank_we = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/prg_irq_mapper_counter.sv
// Module prg_irq_mapper_counter
// Holds the nibble-built reload value, the mode/enable/acknowledge
// flags, the cycle counter and the sticky interrupt. Any register write
// in a cycle wins over that cycle's tick, which is then dropped.
module prg_irq_mapper_counter
    import prg_irq_mapper_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wr_cmd_t cmd,
    input  logic    tick,
    output logic    irq_o
);

    localparam int NIB_N = CNT_W / NIB_W;

    logic [NIB_W-1:0] lat_nib [NIB_N];
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_step;
    logic             mode8_q;
    logic             en_q;
    logic             ack_q;
    logic             irq_q;
    logic             wrap;
    logic             step_ok;

    // one register per reload nibble, each written by its own slot
    for (genvar gi = 0; gi < NIB_N; gi++) begin : g_nib
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_nib[gi] <= '0;
            end else if (cmd.lat_we && (int'(cmd.lat_idx) == gi)) begin
                lat_nib[gi] <= cmd.nib;
            end
        end
        assign reload[gi*NIB_W +: NIB_W] = lat_nib[gi];
    end

    // a tick counts only when enabled and no register write is present
    assign step_ok = tick && en_q && !cmd_any(cmd);

    // next counter value and wrap detection for the current mode
    always_comb begin
        if (mode8_q) begin
            wrap     = &cnt_q[LOW_W-1:0];
            cnt_step = {cnt_q[CNT_W-1:LOW_W],
                        wrap ? reload[LOW_W-1:0] : cnt_q[LOW_W-1:0] + 1'b1};
        end else begin
            wrap     = &cnt_q;
            cnt_step = wrap ? reload : cnt_q + 1'b1;
        end
    end

    // control flags, counter and interrupt, with writes ahead of ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode8_q <= 1'b0;
            en_q    <= 1'b0;
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else if (cmd.ctrl_we) begin
            mode8_q <= cmd.mode8;
            en_q    <= cmd.en;
            ack_q   <= cmd.ack;
            if (cmd.en) begin
                cnt_q <= reload;
            end
        end else if (cmd.clr_we) begin
            irq_q <= 1'b0;
            en_q  <= ack_q;
        end else if (step_ok) begin
            cnt_q <= cnt_step;
            if (wrap) begin
                irq_q <= 1'b1;
                en_q  <= ack_q;
            end
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/prg_irq_mapper_window.sv
// Module prg_irq_mapper_window
// Holds the switchable bank number and maps a CPU address to a ROM
// address: below FIXED_BASE the bank register is used, at or above it
// the last bank is forced. Translation is purely combinational.
module prg_irq_mapper_window #(
    parameter int              ADDR_W     = 16,
    parameter int              BANK_W     = 4,
    parameter int              WIN_W      = 14,
    parameter logic [ADDR_W-1:0] FIXED_BASE = 16'hC000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bank_we,
    input  logic [BANK_W-1:0]       bank_d,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic [BANK_W+WIN_W-1:0] rom_addr
);

    localparam logic [BANK_W-1:0] LAST_BANK = {BANK_W{1'b1}};

    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] bank_sel;

    // bank register load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_we) begin
            bank_q <= bank_d;
        end
    end

    // pick switchable or fixed bank for the address
    always_comb begin
        bank_sel = (cpu_addr >= FIXED_BASE) ? LAST_BANK : bank_q;
    end

    assign rom_addr = {bank_sel, cpu_addr[WIN_W-1:0]};

endmodule

// File: rtl/prg_irq_mapper.sv
// Module prg_irq_mapper (top)
// Cartridge mapper with a cycle-counting interrupt and a program-ROM
// bank window. Assumes one tick per CPU cycle and single-cycle writes.
module prg_irq_mapper
    import prg_irq_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int LOW_W  = 8,
    parameter int BANK_W = 4,
    parameter int WIN_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    tick,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic [BANK_W+WIN_W-1:0] rom_addr,
    output logic                    irq_o
);

    localparam logic [ADDR_W-1:0] FIXED_BASE = ADDR_W'(3) << (ADDR_W - 2);

    wr_cmd_t cmd;

    prg_irq_mapper_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    prg_irq_mapper_counter #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .tick  (tick),
        .irq_o (irq_o)
    );

    prg_irq_mapper_window #(
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .WIN_W      (WIN_W),
        .FIXED_BASE (FIXED_BASE)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_we  (cmd.bank_we),
        .bank_d   (cmd.nib[BANK_W-1:0]),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr)
    );

endmodule

// File: rtl/prg_irq_mapper_chk.sv
// Module prg_irq_mapper_chk
// Port-level properties of the mapper, attached by bind below.
// Assumes the default 16-bit address and 18-bit ROM address widths.
module prg_irq_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        tick,
    input logic [15:0] cpu_addr,
    input logic [17:0] rom_addr,
    input logic        irq_o
);

    logic clr_wr;
    logic bank_wr;
    logic dead_wr;
    logic unused_chk;

    assign clr_wr     = wr_en && (wr_addr[15:12] == 4'hD);
    assign bank_wr    = wr_en && (wr_addr[15:12] == 4'hF);
    assign dead_wr    = wr_en && ((wr_addr[15:12] == 4'hE) || !wr_addr[15]);
    assign unused_chk = ^{wr_addr[11:0], wr_data[7:4]};

    // R9
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !irq_o);

    // R3
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq_o);

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !clr_wr |=> irq_o);

    // R10
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dead_wr && !tick && !irq_o |=> !irq_o);

    // R8
    fixed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (rom_addr[17:14] == 4'hF));

    // R8
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[13:0] == cpu_addr[13:0]);

    // R7
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> (cpu_addr[15:14] == 2'b11) ||
                    (rom_addr[17:14] == $past(wr_data[3:0])));

endmodule

bind prg_irq_mapper prg_irq_mapper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tick     (tick),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr),
    .irq_o    (irq_o)
);

// File: tb/prg_irq_mapper_tb.sv
// Scoreboard bench: the driver task applies one cycle of stimulus,
// advances a requirement-level model and queues the expected outputs;
// the monitor pops and compares them after each clock edge.
module prg_irq_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic [17:0] rom_addr;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        irq;
        logic [17:0] rom;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // requirement-level model state
    logic [3:0]  m_bank  = '0;
    logic        m_mode8 = 1'b0;
    logic        m_en    = 1'b0;
    logic        m_ack   = 1'b0;
    logic [15:0] m_rel   = '0;
    logic [15:0] m_cnt   = '0;
    logic        m_irq   = 1'b0;

    always #5 clk = ~clk;

    prg_irq_mapper u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick     (tick),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr),
        .irq_o    (irq_o)
    );

    function automatic logic [17:0] exp_rom(input logic [15:0] a);
        return {(a >= 16'hC000) ? 4'hF : m_bank, a[13:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance the model by one clock according to the requirements
    task automatic model_step(input logic we, input logic [15:0] a,
                              input logic [7:0] d, input logic tk);
        logic [3:0] s;
        logic       hit;
        s   = a[15:12];
        hit = we && (s inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hF});
        if (hit) begin
            case (s)
                4'h8: m_rel[3:0]   = d[3:0];
                4'h9: m_rel[7:4]   = d[3:0];
                4'hA: m_rel[11:8]  = d[3:0];
                4'hB: m_rel[15:12] = d[3:0];
                4'hC: begin
                    m_mode8 = d[2];
                    m_en    = d[1];
                    m_ack   = d[0];
                    if (d[1]) m_cnt = m_rel;
                end
                4'hD: begin
                    m_irq = 1'b0;
                    m_en  = m_ack;
                end
                default: m_bank = d[3:0];
            endcase
        end else if (tk && m_en) begin
            if (m_mode8) begin
                if (m_cnt[7:0] == 8'hFF) begin
                    m_irq = 1'b1;
                    m_en  = m_ack;
                    m_cnt[7:0] = m_rel[7:0];
                end else begin
                    m_cnt[7:0] = m_cnt[7:0] + 8'd1;
                end
            end else begin
                if (m_cnt == 16'hFFFF) begin
                    m_irq = 1'b1;
                    m_en  = m_ack;
                    m_cnt = m_rel;
                end else begin
                    m_cnt = m_cnt + 16'd1;
                end
            end
        end
    endtask

    // driver: one cycle of stimulus plus the expected result
    task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                       input logic tk, input logic [15:0] ca, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en    = we;
        wr_addr  = a;
        wr_data  = d;
        tick     = tk;
        cpu_addr = ca;
        @(posedge clk);
        model_step(we, a, d, tk);
        e.irq = m_irq;
        e.rom = exp_rom(ca);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 16'h8000, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b1, 16'h8000, tag);
    endtask

    // monitor: compare queued expectations shortly after each edge
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " irq"}, 32'(irq_o), 32'(e.irq));
            check({e.tag, " rom"}, 32'(rom_addr), 32'(e.rom));
        end
    end

    // watchdog
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 irq", 32'(irq_o), 32'h0);
        check("R9 rom", 32'(rom_addr), 32'h00000);
        cpu_addr = 16'hC123;
        #1;
        check("R9 fixed", 32'(rom_addr), 32'h3C123);
        rst_n = 1'b1;

        // R7 bank load, R8 translation
        cyc(1'b1, 16'hF000, 8'h35, 1'b0, 16'h9234, "R7");
        cyc(1'b0, 16'h0, 8'h0, 1'b0, 16'hBFFF, "R8_low");
        cyc(1'b0, 16'h0, 8'h0, 1'b0, 16'hFFFF, "R8_high");
        cyc(1'b0, 16'h0, 8'h0, 1'b0, 16'hC000, "R8_edge");

        // R10 writes to unused slots leave the bank alone
        cyc(1'b1, 16'hE000, 8'h0A, 1'b0, 16'h9000, "R10_e");
        cyc(1'b1, 16'h7F00, 8'h0C, 1'b0, 16'h9000, "R10_low");
        cyc(1'b1, 16'h0000, 8'h09, 1'b0, 16'hA555, "R10_zero");

        // R1 reload built from nibbles: 0xFFFC
        wr(16'h8123, 8'hFC, "R1");
        wr(16'h9000, 8'h0F, "R1");
        wr(16'hAFFF, 8'hFF, "R1");
        wr(16'hB000, 8'h0F, "R1");

        // R2 enable reloads counter; R4 wrap after four ticks
        wr(16'hC000, 8'h03, "R2");
        ticks(3, "R4_pre");
        ticks(1, "R4_wrap");
        // R6 interrupt stays high through another wrap
        ticks(4, "R6");

        // R3 clear, enable follows acknowledge (1); tick dropped (R11)
        cyc(1'b1, 16'hD000, 8'h00, 1'b1, 16'h8000, "R3");
        // R11 bank write with tick: tick dropped, bank becomes 2
        cyc(1'b1, 16'hF000, 8'h02, 1'b1, 16'h8001, "R11");
        ticks(3, "R11_pre");
        ticks(1, "R11_wrap");

        // R4 acknowledge clear: counting stops after the wrap
        wr(16'hD000, 8'h00, "R3");
        wr(16'hC000, 8'h02, "R2");
        ticks(4, "R4_ack0");
        wr(16'hD000, 8'h00, "R3_ack0");
        ticks(6, "R4_stopped");

        // R10 unused-slot write does not drop a tick
        wr(16'hC000, 8'h03, "R2");
        ticks(2, "R10_pre");
        cyc(1'b1, 16'hE000, 8'h00, 1'b1, 16'h8000, "R10_tick");
        ticks(1, "R10_wrap");

        // R5 8-bit wrap keeps the high byte: reload 0xFFFE
        wr(16'hD000, 8'h00, "R3");
        wr(16'h8000, 8'h0E, "R1");
        wr(16'hC000, 8'h07, "R5");
        ticks(1, "R5_pre");
        ticks(1, "R5_wrap8");
        wr(16'hC000, 8'h01, "R2_noload");
        wr(16'hD000, 8'h00, "R3");
        ticks(1, "R5_high_pre");
        ticks(1, "R5_high_wrap");

        // R5 8-bit wrap with a high byte far from 0xFF: reload 0x12FE
        wr(16'hD000, 8'h00, "R3");
        wr(16'hC000, 8'h00, "R2_off");
        wr(16'hB000, 8'h01, "R1");
        wr(16'hA000, 8'h02, "R1");
        wr(16'hC000, 8'h06, "R5");
        ticks(1, "R5_pre2");
        ticks(1, "R5_wrap2");
        ticks(3, "R5_stopped");

        cyc(1'b0, 16'h0, 8'h0, 1'b0, 16'h8000, "idle");
        @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule